// File: doc/BRIEF.md
# Dual-Channel Delayed Gate Generator

This block turns external reference triggers into timed sampling gates for two acquisition channels. Each channel owns a delay timer and a width timer. When a channel accepts a rising edge of its trigger, it counts out its programmed delay. It then holds its gate output high for the programmed number of cycles. While a channel is in its delay or gate interval it reports busy, and further trigger edges are ignored.

A two-bit mode input sets how the triggers reach the channels. In single-channel operation only trigger A is used and channel B stays idle. In split operation each channel follows its own trigger. In shared operation trigger A starts both channels together, and each channel applies its own delay and width. Both trigger inputs may be asynchronous to the clock, so each passes through a synchroniser before its edge is detected. Delay and width values are counted in clock cycles and are sampled when the trigger is accepted.

Top module: `dual_gate_timer`

## Requirements
- R1: While reset is held and right after it is released, gateA, gateB, busyA and busyB are all low.
- R2: A trigger rise is synchronised and edge-detected, then accepted on the third rising clock edge after the trigger input goes high. With a programmed delay D, the gate first reads high after rising clock edge number 3+D counted from the trigger rise. D=0 therefore opens the gate in the cycle right after acceptance.
- R3: A gate stays high for exactly W consecutive cycles, where W is the programmed width, and a width of 0 acts as 1. When the gate falls, the channel is idle.
- R4: busy goes high on the edge that accepts a trigger and stays high through the last gate cycle. It falls together with the gate, and a high gate always comes with a high busy.
- R5: A trigger edge that reaches a channel during its delay or gate interval is ignored, and no extra gate follows.
- R6: Mode encoding: 0 and 3 = single (trigger A drives channel A; channel B never leaves idle and trigger B is ignored); 1 = split (trigger A drives channel A, trigger B drives channel B); 2 = shared (trigger A starts both channels, trigger B is ignored).
- R7: Delay and width are captured when the trigger is accepted, and later changes to those inputs do not alter the interval in progress.
- R8: Only a rising edge starts a channel. A trigger held high for many cycles yields a single gate.
- R9: The delay counter spans the full delay width (28 bits by default) and the width counter spans the full width port (24 bits by default). A delay above 65535 cycles is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigA | input | 1 | Reference trigger A, asynchronous |
| trigB | input | 1 | Reference trigger B, asynchronous |
| mode | input | 2 | Trigger routing mode (see R6) |
| delayA | input | DLY_W | Channel A delay in cycles |
| delayB | input | DLY_W | Channel B delay in cycles |
| widthA | input | WID_W | Channel A gate width in cycles |
| widthB | input | WID_W | Channel B gate width in cycles |
| gateA | output | 1 | Channel A sampling gate |
| gateB | output | 1 | Channel B sampling gate |
| busyA | output | 1 | Channel A in delay or gate interval |
| busyB | output | 1 | Channel B in delay or gate interval |

## Verification
A wrong channel state shows directly on busy and gate. A stuck or skipped state either holds busy high with no gate, or makes the gate open early, late or for the wrong length. The gate rise and fall cycles expose these faults within one interval. A counter that loads the wrong value shifts the gate edges by a fixed number of cycles, and comparing each measured gate against the expected rise cycle and width catches this on the first gate. Routing errors show up as a gate, or a busy flag, on a channel that the mode should keep idle, three edges after the offending trigger edge.

// File: rtl/gate_pkg.sv
package gate_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'd0,
    MODE_SPLIT      = 2'd1,
    MODE_SHARED     = 2'd2,
    MODE_SINGLE_ALT = 2'd3
  } gate_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_GATE  = 2'd2
  } chan_state_e;

  // strobes from the control FSM to one channel's counters
  typedef struct packed {
    logic capture;    // trigger accepted: load delay, hold width
    logic decDelay;   // count delay down
    logic loadWidth;  // start the gate interval
    logic decWidth;   // count width down
  } chan_strobe_t;

endpackage

// File: rtl/gate_trig_sync.sv
module gate_trig_sync #(
  parameter int STAGES = 2  // must be at least 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  output logic riseOut
);

  logic [STAGES-1:0] syncPipe;
  logic              lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe  <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncPipe  <= {syncPipe[STAGES-2:0], trigIn};
      lastLevel <= syncPipe[STAGES-1];
    end
  end

  assign riseOut = syncPipe[STAGES-1] & ~lastLevel;

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigA,
  input  logic               trigB,
  input  logic [1:0]         mode,
  input  logic [NUM_CH-1:0]  delayZero,
  input  logic [NUM_CH-1:0]  delayDone,
  input  logic [NUM_CH-1:0]  widthDone,
  output chan_strobe_t       strobe [NUM_CH],
  output logic [NUM_CH-1:0]  gate,
  output logic [NUM_CH-1:0]  busy
);

  logic riseA, riseB;
  logic [NUM_CH-1:0] start;
  gate_mode_e modeSel;

  gate_trig_sync #(.STAGES(SYNC_STAGES)) u_syncA (
    .clk(clk), .rstN(rstN), .trigIn(trigA), .riseOut(riseA)
  );

  gate_trig_sync #(.STAGES(SYNC_STAGES)) u_syncB (
    .clk(clk), .rstN(rstN), .trigIn(trigB), .riseOut(riseB)
  );

  assign modeSel = gate_mode_e'(mode);

  // trigger routing per mode
  always_comb begin
    start[0] = riseA;
    unique case (modeSel)
      MODE_SPLIT:  start[1] = riseB;
      MODE_SHARED: start[1] = riseA;
      default:     start[1] = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    chan_state_e  curState, nxtState;
    chan_strobe_t stb;

    always_ff @(posedge clk) begin
      if (!rstN) curState <= ST_IDLE;
      else       curState <= nxtState;
    end

    always_comb begin
      nxtState = curState;
      stb      = '0;
      unique case (curState)
        ST_IDLE: begin
          if (start[g]) begin
            stb.capture = 1'b1;
            if (delayZero[g]) begin
              stb.loadWidth = 1'b1;
              nxtState      = ST_GATE;
            end else begin
              nxtState = ST_DELAY;
            end
          end
        end
        ST_DELAY: begin
          if (delayDone[g]) begin
            stb.loadWidth = 1'b1;
            nxtState      = ST_GATE;
          end else begin
            stb.decDelay = 1'b1;
          end
        end
        ST_GATE: begin
          if (widthDone[g]) nxtState = ST_IDLE;
          else              stb.decWidth = 1'b1;
        end
        default: nxtState = ST_IDLE;
      endcase
    end

    assign strobe[g] = stb;
    assign gate[g]   = (curState == ST_GATE);
    assign busy[g]   = (curState != ST_IDLE);
  end

endmodule

// File: rtl/gate_dp.sv
module gate_dp
  import gate_pkg::*;
#(
  parameter int DLY_W = 28,
  parameter int WID_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chan_strobe_t                  strobe [NUM_CH],
  input  logic [NUM_CH-1:0][DLY_W-1:0]  delayIn,
  input  logic [NUM_CH-1:0][WID_W-1:0]  widthIn,
  output logic [NUM_CH-1:0]             delayZero,
  output logic [NUM_CH-1:0]             delayDone,
  output logic [NUM_CH-1:0]             widthDone
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
    logic [DLY_W-1:0] delayCnt;
    logic [WID_W-1:0] widthHold;
    logic [WID_W-1:0] widthCnt;
    logic [WID_W-1:0] widthSrc;

    // width of the interval being opened: live input when the gate opens
    // on the accepting edge, else the captured copy
    assign widthSrc = strobe[g].capture ? widthIn[g] : widthHold;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        delayCnt  <= '0;
        widthHold <= '0;
        widthCnt  <= '0;
      end else begin
        if (strobe[g].capture) begin
          delayCnt  <= delayIn[g] - 1'b1;
          widthHold <= widthIn[g];
        end else if (strobe[g].decDelay) begin
          delayCnt <= delayCnt - 1'b1;
        end
        if (strobe[g].loadWidth) begin
          widthCnt <= (widthSrc == '0) ? '0 : widthSrc - 1'b1;
        end else if (strobe[g].decWidth) begin
          widthCnt <= widthCnt - 1'b1;
        end
      end
    end

    assign delayZero[g] = (delayIn[g] == '0);
    assign delayDone[g] = (delayCnt == '0);
    assign widthDone[g] = (widthCnt == '0);
  end

endmodule

// File: rtl/dual_gate_timer.sv
module dual_gate_timer
  import gate_pkg::*;
#(
  parameter int DLY_W       = 28,
  parameter int WID_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigA,
  input  logic             trigB,
  input  logic [1:0]       mode,
  input  logic [DLY_W-1:0] delayA,
  input  logic [DLY_W-1:0] delayB,
  input  logic [WID_W-1:0] widthA,
  input  logic [WID_W-1:0] widthB,
  output logic             gateA,
  output logic             gateB,
  output logic             busyA,
  output logic             busyB
);

  chan_strobe_t                 strobe [NUM_CH];
  logic [NUM_CH-1:0]            delayZero, delayDone, widthDone;
  logic [NUM_CH-1:0]            gateVec, busyVec;
  logic [NUM_CH-1:0][DLY_W-1:0] delayVec;
  logic [NUM_CH-1:0][WID_W-1:0] widthVec;

  assign delayVec = {delayB, delayA};
  assign widthVec = {widthB, widthA};

  gate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigA(trigA), .trigB(trigB), .mode(mode),
    .delayZero(delayZero), .delayDone(delayDone), .widthDone(widthDone),
    .strobe(strobe), .gate(gateVec), .busy(busyVec)
  );

  gate_dp #(.DLY_W(DLY_W), .WID_W(WID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .delayIn(delayVec), .widthIn(widthVec),
    .delayZero(delayZero), .delayDone(delayDone), .widthDone(widthDone)
  );

  assign gateA = gateVec[0];
  assign gateB = gateVec[1];
  assign busyA = busyVec[0];
  assign busyB = busyVec[1];

endmodule

// File: rtl/dual_gate_timer_chk.sv
module dual_gate_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       gateA,
  input logic       gateB,
  input logic       busyA,
  input logic       busyB
);

  // R4
  gate_busy_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateA |-> busyA);

  // R4
  gate_busy_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateB |-> busyB);

  // R3
  gate_end_idle_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateA) |-> !busyA);

  // R3
  gate_end_idle_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateB) |-> !busyB);

  // R4
  busy_end_gate_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyA) |-> $past(gateA));

  // R4
  busy_end_gate_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyB) |-> $past(gateB));

  // R6
  single_b_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1 && mode != 2'd2 && !busyB) |=> !busyB);

endmodule

bind dual_gate_timer dual_gate_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(mode),
  .gateA(gateA), .gateB(gateB), .busyA(busyA), .busyB(busyB)
);

// File: tb/dual_gate_timer_bench.sv
module dual_gate_timer_bench;

  localparam int DLY_W = 28;
  localparam int WID_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             trigA = 1'b0, trigB = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [DLY_W-1:0] delayA = '0, delayB = '0;
  logic [WID_W-1:0] widthA = '0, widthB = '0;
  logic             gateA, gateB, busyA, busyB;

  dual_gate_timer u_dual_gate_timer (
    .clk(clk), .rstN(rstN), .trigA(trigA), .trigB(trigB), .mode(mode),
    .delayA(delayA), .delayB(delayB), .widthA(widthA), .widthB(widthB),
    .gateA(gateA), .gateB(gateB), .busyA(busyA), .busyB(busyB)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    int    rise;
    int    width;
    string tag;
  } exp_t;

  exp_t qA[$], qB[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard driver side: expected gate for a trigger raised at cycle t
  task automatic expectGate(input int ch, input int t, input int d, input int w, input string tag);
    exp_t e;
    e.rise  = t + 3 + d;
    e.width = (w == 0) ? 1 : w;
    e.tag   = tag;
    if (ch == 0) qA.push_back(e); else qB.push_back(e);
  endtask

  // which: 0 = A, 1 = B, 2 = both
  task automatic trigUp(input int which, output int t);
    @(negedge clk);
    if (which != 1) trigA = 1'b1;
    if (which != 0) trigB = 1'b1;
    t = cyc;
  endtask

  task automatic trigDown(input int which);
    @(negedge clk);
    if (which != 1) trigA = 1'b0;
    if (which != 0) trigB = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (qA.size() != 0 || qB.size() != 0 || busyA || busyB) @(negedge clk);
    waitCyc(5);
  endtask

  // scoreboard monitor side
  logic prevA = 1'b0, prevB = 1'b0;
  int   riseA = 0, riseB = 0;

  always @(negedge clk) begin
    exp_t e;
    if (rstN && !done) begin
      if (gateA && !prevA) riseA = cyc;
      if (!gateA && prevA) begin
        if (qA.size() == 0) check(1'b0, "R5 R6 unexpected gate on channel A", cyc, -1);
        else begin
          e = qA.pop_front();
          check(riseA == e.rise, {e.tag, " gate A rise cycle"}, riseA, e.rise);
          check(cyc - riseA == e.width, {e.tag, " gate A width"}, cyc - riseA, e.width);
        end
      end
      if (gateB && !prevB) riseB = cyc;
      if (!gateB && prevB) begin
        if (qB.size() == 0) check(1'b0, "R5 R6 unexpected gate on channel B", cyc, -1);
        else begin
          e = qB.pop_front();
          check(riseB == e.rise, {e.tag, " gate B rise cycle"}, riseB, e.rise);
          check(cyc - riseB == e.width, {e.tag, " gate B width"}, cyc - riseB, e.width);
        end
      end
    end
    prevA = gateA;
    prevB = gateB;
  end

  initial begin
    int t, t2;
    // R1 reset state
    waitCyc(3);
    check({gateA, gateB, busyA, busyB} == 4'b0, "R1 outputs during reset", {gateA, gateB, busyA, busyB}, 0);
    rstN = 1'b1;
    waitCyc(3);
    check({gateA, gateB, busyA, busyB} == 4'b0, "R1 outputs after reset", {gateA, gateB, busyA, busyB}, 0);

    // R2 R3 R4 split mode, both triggers together, zero delay and zero width on B
    mode = 2'd1; delayA = 5; widthA = 4; delayB = 0; widthB = 0;
    trigUp(2, t);
    expectGate(0, t, 5, 4, "R2 R3 split A");
    expectGate(1, t, 0, 0, "R2 R3 split B zero delay and width");
    waitUntil(t + 2);
    check(busyA == 1'b0, "R4 busyA before acceptance", busyA, 0);
    waitUntil(t + 3);
    check(busyA == 1'b1, "R4 busyA at acceptance", busyA, 1);
    check(gateB == 1'b1, "R2 gateB right after acceptance with delay 0", gateB, 1);
    trigDown(2);
    waitIdle();

    // R6 shared mode: A starts both channels with own delays
    mode = 2'd2; delayA = 2; widthA = 3; delayB = 10; widthB = 2;
    trigUp(0, t);
    expectGate(0, t, 2, 3, "R6 shared A");
    expectGate(1, t, 10, 2, "R6 shared B");
    trigDown(0);
    waitIdle();
    // R6 shared mode ignores trigger B
    trigUp(1, t);
    trigDown(1);
    waitUntil(t + 5);
    check(busyA == 1'b0, "R6 shared trigB busyA", busyA, 0);
    check(busyB == 1'b0, "R6 shared trigB busyB", busyB, 0);
    waitIdle();

    // R6 single mode: only A, B quiet
    mode = 2'd0; delayA = 1; widthA = 1; delayB = 0; widthB = 1;
    trigUp(2, t);
    expectGate(0, t, 1, 1, "R6 single A");
    waitUntil(t + 4);
    check(busyB == 1'b0, "R6 single mode busyB", busyB, 0);
    trigDown(2);
    waitIdle();
    mode = 2'd3;
    trigUp(1, t);
    trigDown(1);
    waitUntil(t + 5);
    check(busyB == 1'b0, "R6 mode 3 trigB busyB", busyB, 0);
    waitIdle();

    // R5 retrigger during delay and during gate
    mode = 2'd1; delayA = 20; widthA = 5;
    trigUp(0, t);
    expectGate(0, t, 20, 5, "R5 retrigger A");
    waitCyc(2);
    trigDown(0);
    waitCyc(6);
    trigUp(0, t2);
    waitCyc(2);
    trigDown(0);
    waitUntil(t + 24);
    trigUp(0, t2);
    waitCyc(2);
    trigDown(0);
    waitIdle();
    check(busyA == 1'b0, "R5 idle after ignored retriggers", busyA, 0);

    // R7 inputs changed after acceptance have no effect
    delayA = 4; widthA = 3;
    trigUp(0, t);
    expectGate(0, t, 4, 3, "R7 captured values");
    waitUntil(t + 3);
    delayA = 50; widthA = 9;
    trigDown(0);
    waitIdle();

    // R8 held level gives one gate
    delayB = 3; widthB = 2;
    trigUp(1, t);
    expectGate(1, t, 3, 2, "R8 held trigger B");
    waitCyc(40);
    trigDown(1);
    waitIdle();

    // R9 delay beyond 16 bits
    delayA = 65540; widthA = 3;
    trigUp(0, t);
    expectGate(0, t, 65540, 3, "R9 long delay");
    trigDown(0);
    waitUntil(t + 3 + 65536);
    check(busyA == 1'b1 && gateA == 1'b0, "R9 still in delay", {busyA, gateA}, 2);
    waitIdle();

    check(qA.size() == 0 && qB.size() == 0, "R2 no pending gates", qA.size() + qB.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule